// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external host read and write a bank of internal registers over a four-wire serial link. The block uses an active-low chip select, a serial clock, a data input and a data output. The data output has a separate enable that controls the pad's tri-state buffer. All logic runs on the system clock. The serial clock, chip select and data input pass through two-flop synchronizers, and the serial clock edges are detected in the system clock domain. The system clock must therefore run several times faster than the serial clock.

Every transfer starts with a command byte. The command byte carries a direction bit and a 7-bit register address. One, two or three data bytes follow, most significant byte first. The address selects the number of data bytes through a built-in width map. The map covers registers of 8, 12, 16 and 24 bits.

On the register side, the block presents an address and write data with a one-cycle write strobe. For reads, it issues a one-cycle read strobe and captures the returned read data. A range of addresses is treated as clear-on-read. When a read of one of these addresses completes, the block issues a one-cycle clear strobe so that the register file can reset that register.

Top module: `spi_regport`

## Requirements
- R1: In the command byte, bit 7 set to 1 selects a write and bit 7 set to 0 selects a read. Bits 6..0 hold the register address, which is presented on `reg_addr`.
- R2: `din` is captured on falling edges of `sclk`. `dout` changes only on rising edges. The first read-data bit appears after the rising edge that follows the command byte, so a host that samples on falling edges receives the bits in order.
- R3: The number of data bytes depends on the address. Addresses 0x00-0x0F take 3 bytes (24-bit registers). Addresses 0x10-0x3F take 2 bytes (16-bit registers). Addresses 0x40-0x5F take 2 bytes and hold 12-bit registers. Addresses 0x60-0x7F take 1 byte (8-bit registers). All data moves most significant byte first.
- R4: At the end of the last data byte of a write, `reg_we` pulses for exactly one cycle. At that point `reg_wdata` holds the received value, right-justified and masked to the register width.
- R5: After the command byte of a read, `reg_re` pulses for exactly one system clock. `reg_rdata` is captured at the end of that cycle. A write produces no `reg_re`.
- R6: A read of a 12-bit register returns 16 bits, with bit 11 copied into bits 15..12.
- R7: `dout_oe` is high only during the data phase of a read. It is never high during a write. It is low within four system clocks once `cs_n` has been high.
- R8: If `cs_n` rises before the last data bit, the transfer is abandoned. No `reg_we` and no `reg_clr` are produced, and the register keeps its previous contents.
- R9: A completed read of an address in 0x04-0x0F pulses `reg_clr` for one cycle, on the falling `sclk` edge of the final data bit. A read of any other address produces no `reg_clr`.
- R10: While `rst_n` is low, `dout_oe`, `reg_we`, `reg_re` and `reg_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host, idles high |
| din | input | 1 | Serial data from the host |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Output enable for the `dout` pad buffer |
| reg_addr | output | 7 | Register address from the command byte |
| reg_wdata | output | 24 | Write data, right-justified to the register width |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | 24 | Read data from the register file |
| reg_clr | output | 1 | One-cycle clear strobe after a clear-on-read read |

## Verification
The bench writes and then reads back registers at both ends of every width band.

- If the width map were off at a band edge, the transfer would have the wrong number of bytes and the readback would come back shifted.
- If the output were launched on the wrong serial edge, every read would be off by one bit.
- If sign extension were missing from the 12-bit reads, a negative value written to 0x40 or 0x47 would come back with clear upper bits.

The bench also cuts a write short and cuts a read of a clear-on-read address short. A design that committed partial transfers would corrupt the first register and would erase the second one before the full read that follows.

// File: rtl/spi_regport_pkg.sv
// Shared types for the serial register port.
// Assumes: register widths are limited to the four encodings below.
package spi_regport_pkg;

    // Register width class returned by the width map.
    typedef enum logic [1:0] {
        WID_8  = 2'd0,
        WID_12 = 2'd1,
        WID_16 = 2'd2,
        WID_24 = 2'd3
    } wid_e;

    // Position within one chip-select frame.
    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

endpackage

// File: rtl/spi_edge_sync.sv
// Synchronizes the serial inputs into the system clock domain and
// detects rising and falling edges of the serial clock.
// Assumes: the system clock is at least four times the serial clock rate.
// The data input passes through the same number of stages as the serial
// clock, so the value taken at a detected edge is the value the host
// presented around that edge.
module spi_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic din,
    output logic cs_act,
    output logic sclk_fall,
    output logic sclk_rise,
    output logic din_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] cs_q;
    logic [TOP:0] sck_q;
    logic [TOP:0] din_q;
    logic         sck_d;

    // Synchronizer chains, plus one delayed copy of the serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= '1;
            sck_q <= '1;
            din_q <= '0;
            sck_d <= 1'b1;
        end else begin
            cs_q  <= {cs_q[TOP-1:0], cs_n};
            sck_q <= {sck_q[TOP-1:0], sclk};
            din_q <= {din_q[TOP-1:0], din};
            sck_d <= sck_q[TOP];
        end
    end

    assign cs_act    = ~cs_q[TOP];
    assign sclk_fall = sck_d & ~sck_q[TOP];
    assign sclk_rise = ~sck_d & sck_q[TOP];
    assign din_s     = din_q[TOP];

endmodule

// File: rtl/spi_width_map.sv
// Maps a register address to its width class, its byte count on the
// serial link and its clear-on-read attribute. The address bands are
// set by parameters.
// Assumes: W24_END <= W16_END <= W12_END and RWR_LO <= RWR_HI.
module spi_width_map
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W  = 7,
    parameter int W24_END = 16,
    parameter int W16_END = 64,
    parameter int W12_END = 96,
    parameter int RWR_LO  = 4,
    parameter int RWR_HI  = 15
) (
    input  logic [ADDR_W-1:0] addr,
    output wid_e              wid,
    output logic [1:0]        nbytes,
    output logic              clr_en
);
    localparam logic [ADDR_W-1:0] B24 = ADDR_W'(W24_END);
    localparam logic [ADDR_W-1:0] B16 = ADDR_W'(W16_END);
    localparam logic [ADDR_W-1:0] B12 = ADDR_W'(W12_END);
    localparam logic [ADDR_W-1:0] CLO = ADDR_W'(RWR_LO);
    localparam logic [ADDR_W-1:0] CHI = ADDR_W'(RWR_HI);

    // Band lookup: the lowest band that contains the address wins.
    always_comb begin
        if (addr < B24) begin
            wid    = WID_24;
            nbytes = 2'd3;
        end else if (addr < B16) begin
            wid    = WID_16;
            nbytes = 2'd2;
        end else if (addr < B12) begin
            wid    = WID_12;
            nbytes = 2'd2;
        end else begin
            wid    = WID_8;
            nbytes = 2'd1;
        end
        clr_en = (addr >= CLO) && (addr <= CHI);
    end

endmodule

// File: rtl/spi_frame_ctrl.sv
// Frame sequencer. It shifts in the command byte, decodes the direction
// and the address, counts data bytes against the width map, issues the
// register strobes and shifts read data out.
// Assumes: edge pulses and the synchronized data input come from
// spi_edge_sync, and the register file drives reg_rdata during reg_re.
module spi_frame_ctrl
    import spi_regport_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 24,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_fall,
    input  logic              sclk_rise,
    input  logic              din_s,
    input  wid_e              wid,
    input  logic [1:0]        nbytes,
    input  logic              clr_en,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    output logic              reg_clr,
    output logic              dout,
    output logic              dout_oe
);
    localparam int                CNT_W    = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [DATA_W-1:0] ONES     = '1;

    phase_e            phase;
    logic [CNT_W-1:0]  bit_cnt;
    logic [1:0]        byte_cnt;
    logic              is_rd;
    logic [DATA_W-1:0] rx;
    logic [DATA_W-1:0] tx;
    logic [DATA_W-1:0] rx_next;

    // Keeps the received value within the bits the register really holds.
    function automatic logic [DATA_W-1:0] trim(input logic [DATA_W-1:0] v, input wid_e w);
        case (w)
            WID_8:   trim = v & (ONES >> (DATA_W - 8));
            WID_12:  trim = v & (ONES >> (DATA_W - 12));
            WID_16:  trim = v & (ONES >> (DATA_W - 16));
            default: trim = v;
        endcase
    endfunction

    // Builds the value sent to the host: 12-bit registers are sign-extended to 16 bits.
    function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v, input wid_e w);
        if (w == WID_12)
            widen = {{(DATA_W-12){v[11]}}, v[11:0]} & (ONES >> (DATA_W - 16));
        else
            widen = trim(v, w);
    endfunction

    assign rx_next = {rx[DATA_W-2:0], din_s};

    // Frame state, shifting and strobes. Strobes last one cycle; a released select clears the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_CMD;
            bit_cnt   <= '0;
            byte_cnt  <= '0;
            is_rd     <= 1'b0;
            rx        <= '0;
            tx        <= '0;
            cmd_addr  <= '0;
            reg_wdata <= '0;
            reg_we    <= 1'b0;
            reg_re    <= 1'b0;
            reg_clr   <= 1'b0;
            dout      <= 1'b0;
            dout_oe   <= 1'b0;
        end else begin
            reg_we  <= 1'b0;
            reg_re  <= 1'b0;
            reg_clr <= 1'b0;
            if (!cs_act) begin
                phase    <= PH_CMD;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                is_rd    <= 1'b0;
                dout     <= 1'b0;
                dout_oe  <= 1'b0;
            end else begin
                if (reg_re)
                    tx <= widen(reg_rdata, wid) << (DATA_W - BYTE_W * int'(nbytes));
                if (sclk_fall && phase != PH_DONE) begin
                    rx      <= rx_next;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == LAST_BIT) begin
                        if (phase == PH_CMD) begin
                            cmd_addr <= rx_next[ADDR_W-1:0];
                            is_rd    <= ~rx[BYTE_W-2];
                            reg_re   <= ~rx[BYTE_W-2];
                            byte_cnt <= '0;
                            phase    <= PH_DATA;
                        end else if (byte_cnt == nbytes - 2'd1) begin
                            phase <= PH_DONE;
                            if (is_rd) begin
                                reg_clr <= clr_en;
                            end else begin
                                reg_we    <= 1'b1;
                                reg_wdata <= trim(rx_next, wid);
                            end
                        end else begin
                            byte_cnt <= byte_cnt + 2'd1;
                        end
                    end
                end
                if (sclk_rise && phase == PH_DATA && is_rd) begin
                    dout    <= tx[DATA_W-1];
                    tx      <= tx << 1;
                    dout_oe <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/spi_regport.sv
// Top level of the serial register port. It connects the input
// synchronizer, the address width map and the frame sequencer. The
// dout pad buffer lives outside this block and is driven by dout_oe.
// Assumes: sclk idles high and each phase of sclk lasts at least four system clocks.
module spi_regport #(
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 24,
    parameter int STAGES  = 2,
    parameter int W24_END = 16,
    parameter int W16_END = 64,
    parameter int W12_END = 96,
    parameter int RWR_LO  = 4,
    parameter int RWR_HI  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_clr
);
    import spi_regport_pkg::*;

    logic       cs_act;
    logic       sclk_fall;
    logic       sclk_rise;
    logic       din_s;
    wid_e       wid;
    logic [1:0] nbytes;
    logic       clr_en;

    spi_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .din       (din),
        .cs_act    (cs_act),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .din_s     (din_s)
    );

    spi_width_map #(
        .ADDR_W  (ADDR_W),
        .W24_END (W24_END),
        .W16_END (W16_END),
        .W12_END (W12_END),
        .RWR_LO  (RWR_LO),
        .RWR_HI  (RWR_HI)
    ) u_map (
        .addr   (reg_addr),
        .wid    (wid),
        .nbytes (nbytes),
        .clr_en (clr_en)
    );

    spi_frame_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_fall (sclk_fall),
        .sclk_rise (sclk_rise),
        .din_s     (din_s),
        .wid       (wid),
        .nbytes    (nbytes),
        .clr_en    (clr_en),
        .reg_rdata (reg_rdata),
        .cmd_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_clr   (reg_clr),
        .dout      (dout),
        .dout_oe   (dout_oe)
    );

endmodule

// File: rtl/spi_regport_chk.sv
// Protocol checker for spi_regport, attached with bind below. It
// observes only the ports of the block.
module spi_regport_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic dout_oe,
    input logic reg_we,
    input logic reg_re,
    input logic reg_clr
);
    // R4
    we_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5
    re_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R5
    re_not_with_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_re && reg_we));

    // R7
    oe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dout_oe);

    // R7
    oe_not_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !dout_oe);

    // R9
    clr_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clr |-> (dout_oe && !reg_we));

    // R9
    clr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_clr |=> !reg_clr);
endmodule

bind spi_regport spi_regport_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .dout_oe (dout_oe),
    .reg_we  (reg_we),
    .reg_re  (reg_re),
    .reg_clr (reg_clr)
);

// File: tb/spi_regport_test.sv
module spi_regport_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        din = 1'b0;
    logic        dout;
    logic        dout_oe;
    logic [6:0]  reg_addr;
    logic [23:0] reg_wdata;
    logic        reg_we;
    logic        reg_re;
    logic [23:0] reg_rdata;
    logic        reg_clr;

    logic [23:0] mem [0:127];
    int          we_cnt = 0, re_cnt = 0, clr_cnt = 0, oe_wr_cnt = 0, oe_rd_cnt = 0;
    logic [23:0] last_wdata = '0;
    logic        frame_wr = 1'b0;
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    spi_regport uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dout(dout), .dout_oe(dout_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .reg_clr(reg_clr)
    );

    // Register file model with clear-on-read support.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 128; i++) mem[i] <= '0;
        end else if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
        end else if (reg_clr) begin
            mem[reg_addr] <= '0;
        end
    end
    assign reg_rdata = mem[reg_addr];

    // Strobe and output-enable monitors.
    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                we_cnt     <= we_cnt + 1;
                last_wdata <= reg_wdata;
            end
            if (reg_re)  re_cnt  <= re_cnt + 1;
            if (reg_clr) clr_cnt <= clr_cnt + 1;
            if (dout_oe && frame_wr)  oe_wr_cnt <= oe_wr_cnt + 1;
            if (dout_oe && !frame_wr) oe_rd_cnt <= oe_rd_cnt + 1;
        end
    end

    // Byte count per address band (R3).
    function automatic int nb_of(input logic [6:0] a);
        if (a < 7'h10)      nb_of = 3;
        else if (a < 7'h60) nb_of = 2;
        else                nb_of = 1;
    endfunction

    // Value kept by a register of the given address (R4).
    function automatic logic [23:0] kept(input logic [6:0] a, input logic [23:0] v);
        if (a < 7'h10)      kept = v;
        else if (a < 7'h40) kept = {8'h0, v[15:0]};
        else if (a < 7'h60) kept = {12'h0, v[11:0]};
        else                kept = {16'h0, v[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One frame: command byte plus data bytes; stop_bits > 0 raises select early.
    task automatic xfer(input logic [7:0] cmd, input int nb, input logic [23:0] wd,
                        input int stop_bits, output logic [23:0] rd);
        logic [31:0] frame;
        int          total;
        @(negedge clk);
        frame    = {cmd, wd << (8 * (3 - nb))};
        total    = (stop_bits > 0) ? stop_bits : 8 * (nb + 1);
        frame_wr = cmd[7];
        rd       = '0;
        cs_n     = 1'b0;
        #100;
        for (int i = 0; i < total; i++) begin
            din = frame[31 - i];
            #80 sclk = 1'b0;
            if (i >= 8) rd = {rd[22:0], dout};
            #80 sclk = 1'b1;
        end
        #100 cs_n = 1'b1;
        #200;
    endtask

    localparam logic [54:0] VECS [9] = '{
        {7'h10, 24'h00BEEF, 24'h00BEEF},
        {7'h3F, 24'h001234, 24'h001234},
        {7'h40, 24'h00FABC, 24'h00FABC},
        {7'h5F, 24'h000123, 24'h000123},
        {7'h47, 24'h007800, 24'h00F800},
        {7'h60, 24'h0000A5, 24'h0000A5},
        {7'h7F, 24'h00003C, 24'h00003C},
        {7'h0F, 24'hC0FFEE, 24'hC0FFEE},
        {7'h00, 24'h123456, 24'h123456}
    };

    initial begin
        logic [23:0] rd;
        logic [6:0]  a;
        logic [23:0] w, e;
        int          we0, re0, clr0;

        repeat (4) @(negedge clk);
        // R10: reset state
        chk(dout_oe == 1'b0, "R10 oe", 32'(dout_oe), 0);
        chk(reg_we == 1'b0 && reg_re == 1'b0 && reg_clr == 1'b0, "R10 strobes",
            32'({reg_we, reg_re, reg_clr}), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector walk: write then read back at every band edge.
        for (int k = 0; k < 9; k++) begin
            {a, w, e} = VECS[k];
            we0 = we_cnt; re0 = re_cnt;
            xfer({1'b1, a}, nb_of(a), w, 0, rd);
            // R1 R4: one write strobe, masked data, no read strobe
            chk(we_cnt == we0 + 1, "R4 we count", 32'(we_cnt - we0), 1);
            chk(last_wdata == kept(a, w), "R4 wdata", 32'(last_wdata), 32'(kept(a, w)));
            chk(re_cnt == re0, "R5 no re on write", 32'(re_cnt - re0), 0);
            we0 = we_cnt;
            xfer({1'b0, a}, nb_of(a), 24'h0, 0, rd);
            // R2 R3 R6: readback order, length and sign extension
            chk(rd == e, "R3 R6 readback", 32'(rd), 32'(e));
            chk(re_cnt == re0 + 1, "R5 re count", 32'(re_cnt - re0), 1);
            chk(we_cnt == we0, "R1 read does not write", 32'(we_cnt - we0), 0);
        end

        // R7: enable never up in writes, seen in reads, down after select release
        chk(oe_wr_cnt == 0, "R7 oe in write", 32'(oe_wr_cnt), 0);
        chk(oe_rd_cnt > 0, "R7 oe in read", 32'(oe_rd_cnt), 1);
        chk(dout_oe == 1'b0, "R7 oe after cs", 32'(dout_oe), 0);

        // R8: aborted write keeps the old contents
        xfer(8'hA0, 2, 24'h001111, 0, rd);
        we0 = we_cnt;
        xfer(8'hA0, 2, 24'h002222, 12, rd);
        chk(we_cnt == we0, "R8 no we on abort", 32'(we_cnt - we0), 0);
        xfer(8'h20, 2, 24'h0, 0, rd);
        chk(rd == 24'h001111, "R8 value kept", 32'(rd), 32'h1111);

        // R8 R9: aborted clear-on-read read does not clear
        xfer(8'h85, 3, 24'hABCDEF, 0, rd);
        clr0 = clr_cnt;
        xfer(8'h05, 3, 24'h0, 20, rd);
        chk(clr_cnt == clr0, "R8 no clr on abort", 32'(clr_cnt - clr0), 0);
        xfer(8'h05, 3, 24'h0, 0, rd);
        chk(rd == 24'hABCDEF, "R9 read before clear", 32'(rd), 32'hABCDEF);
        chk(clr_cnt == clr0 + 1, "R9 clr pulse", 32'(clr_cnt - clr0), 1);
        xfer(8'h05, 3, 24'h0, 0, rd);
        chk(rd == 24'h0, "R9 cleared", 32'(rd), 0);

        // R9: a read outside the clear range gives no clear strobe
        clr0 = clr_cnt;
        xfer(8'h00, 3, 24'h0, 0, rd);
        chk(clr_cnt == clr0, "R9 no clr at 0x00", 32'(clr_cnt - clr0), 0);
        chk(rd == 24'h123456, "R9 0x00 intact", 32'(rd), 32'h123456);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #1500000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule